// File: doc/BRIEF.md
# Virtual Supervisor Interrupt Pending Generator

This block derives the three hypervisor-level interrupt pending bits from their sources: the guest-level external pending bit, the guest-level timer pending bit, and the supervisor guest-external pending bit. Sources are software-set pending bits, a vector of guest external interrupt lines with a stored enable mask, a stored selector that picks one guest external line, platform virtual external lines, and a timer made of a free-running time input, a stored guest offset and a stored compare value.

The stored state (enable mask, offset, compare value and selector) sits behind a plain single-cycle write port. All stored values are brought out as plain outputs so read paths can use them and the pending bits as read-only aliases. The block has no streaming data path, so no port uses a valid/ready handshake. A write can never be refused and needs no back-pressure. The pending bits are continuous levels.

The parameter `GEI_CNT` sets how many guest external lines exist (default 5). Lines are numbered 1 to `GEI_CNT`, and position 0 is never implemented.

Top module: `vs_irq_pending_gen`

## Requirements
- R1: `vseip` equals `sw_vseip` OR `plat_vseip` OR `gext_pend[s]`, where `s` is the stored selector; when `s` is 0 no guest line contributes.
- R2: `vstip` equals `sw_vstip` OR a registered flag that is 1 when `(time_now + tdelta_q) mod 2^64 >= tcmp_q`, the sum taken unsigned and wrapping.
- R3: `sgeip` is the OR over positions 1..GEI_CNT of `gext_pend & gext_en_q`; `gext_pend[0]` never affects any output.
- R4: Bit 0 of `gext_en_q` always reads 0; writes to it are discarded.
- R5: Register select encoding on `cfg_sel`: 0 = guest enable mask (`cfg_wdata[GEI_CNT:0]`), 1 = time offset, 2 = compare value, 3 = selector (`cfg_wdata[5:0]`). A write with `cfg_we` high takes effect on the next rising clock edge.
- R6: A selector write whose 6-bit field value exceeds `GEI_CNT` leaves the stored selector unchanged; values 0..GEI_CNT are stored.
- R7: The timer flag updates one clock edge after `time_now`, offset or compare changes; before that edge `vstip` keeps its old value.
- R8: Reset (`rst_n` low) clears the selector, enable mask, offset and timer flag to 0, and sets the compare value to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_vseip | input | 1 | Software-set guest external pending bit |
| sw_vstip | input | 1 | Software-set guest timer pending bit |
| plat_vseip | input | 1 | Platform virtual external interrupt line |
| gext_pend | input | GEI_CNT+1 | Guest external interrupt pending lines (bit 0 unused) |
| time_now | input | 64 | Free-running time value |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 64 | Register write data |
| vseip | output | 1 | Guest external pending |
| vstip | output | 1 | Guest timer pending |
| sgeip | output | 1 | Supervisor guest-external pending |
| gext_en_q | output | GEI_CNT+1 | Stored guest enable mask |
| tdelta_q | output | 64 | Stored time offset |
| tcmp_q | output | 64 | Stored compare value |
| gsel_q | output | SEL_W | Stored selector |

## Verification
The bench sweeps every pending pattern against every enable pattern, and every selector against every pending pattern. A design that lets line 0 count or indexes the vector off by one would raise a pending bit with no enabled source. All 64 selector field values are written. A design that stores an out-of-range selector, or truncates it to the low bits, would point at a wrong line. The timer is probed at equality, one below and one above, and across the 64-bit wrap. A design that widens the sum or uses a strict compare would flag at the wrong time. One probe just before the clock edge catches a comparator that is not registered.

// File: rtl/vsirq_pkg.sv
package vsirq_pkg;
  // register select encoding of the write port
  typedef enum logic [1:0] {
    REG_GEN   = 2'd0,
    REG_DELTA = 2'd1,
    REG_CMP   = 2'd2,
    REG_SEL   = 2'd3
  } cfg_sel_e;

  localparam int SEL_FIELD_W = 6;
endpackage

// File: rtl/vsirq_cfg_regs.sv
module vsirq_cfg_regs
  import vsirq_pkg::*;
#(
  parameter int GEI_CNT = 5,
  parameter int TW      = 64,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [TW-1:0]      wdata,
  output logic [GEI_CNT:0]   en_q,
  output logic [TW-1:0]      delta_q,
  output logic [TW-1:0]      cmp_q,
  output logic [SEL_W-1:0]   gsel_q
);
  localparam logic [SEL_FIELD_W-1:0] SEL_MAX = SEL_FIELD_W'(GEI_CNT);

  cfg_sel_e sel_e;
  logic [SEL_FIELD_W-1:0] sel_field;
  logic sel_legal;

  assign sel_e     = cfg_sel_e'(sel);
  assign sel_field = wdata[SEL_FIELD_W-1:0];
  assign sel_legal = sel_field <= SEL_MAX;

  // bit 0 of the enable mask is hard-wired to zero
  assign en_q[0] = 1'b0;
  for (genvar g = 1; g <= GEI_CNT; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)                       en_q[g] <= 1'b0;
      else if (we && sel_e == REG_GEN)  en_q[g] <= wdata[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delta_q <= '0;
      cmp_q   <= '1;
      gsel_q  <= '0;
    end else if (we) begin
      case (sel_e)
        REG_DELTA: delta_q <= wdata;
        REG_CMP:   cmp_q   <= wdata;
        REG_SEL:   if (sel_legal) gsel_q <= sel_field[SEL_W-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/vsirq_ext_sel.sv
module vsirq_ext_sel #(
  parameter int GEI_CNT = 5,
  parameter int SEL_W   = 3
) (
  input  logic [GEI_CNT:0]  pend,
  input  logic [GEI_CNT:0]  en,
  input  logic [SEL_W-1:0]  gsel,
  output logic              picked,
  output logic              any_enabled
);
  logic [GEI_CNT:0] hit;
  logic [GEI_CNT:0] masked;

  for (genvar g = 0; g <= GEI_CNT; g++) begin : g_line
    if (g == 0) begin : g_zero
      assign hit[g]    = 1'b0;
      assign masked[g] = 1'b0;
    end else begin : g_real
      assign hit[g]    = (gsel == SEL_W'(g)) & pend[g];
      assign masked[g] = pend[g] & en[g];
    end
  end

  assign picked      = |hit;
  assign any_enabled = |masked;
endmodule

// File: rtl/vsirq_timer_cmp.sv
module vsirq_timer_cmp #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic [TW-1:0] delta,
  input  logic [TW-1:0] cmp,
  output logic          due_q
);
  logic [TW-1:0] guest_time;
  assign guest_time = time_now + delta;   // wraps modulo 2^TW

  always_ff @(posedge clk) begin
    if (!rst_n) due_q <= 1'b0;
    else        due_q <= guest_time >= cmp;
  end
endmodule

// File: rtl/vs_irq_pending_gen.sv
module vs_irq_pending_gen #(
  parameter int GEI_CNT = 5,
  parameter int TW      = 64,
  localparam int SEL_W  = $clog2(GEI_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_vseip,
  input  logic              sw_vstip,
  input  logic              plat_vseip,
  input  logic [GEI_CNT:0]  gext_pend,
  input  logic [TW-1:0]     time_now,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [TW-1:0]     cfg_wdata,
  output logic              vseip,
  output logic              vstip,
  output logic              sgeip,
  output logic [GEI_CNT:0]  gext_en_q,
  output logic [TW-1:0]     tdelta_q,
  output logic [TW-1:0]     tcmp_q,
  output logic [SEL_W-1:0]  gsel_q
);
  logic picked, any_en, due_q;

  vsirq_cfg_regs #(.GEI_CNT(GEI_CNT), .TW(TW), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .en_q(gext_en_q), .delta_q(tdelta_q), .cmp_q(tcmp_q), .gsel_q(gsel_q)
  );

  vsirq_ext_sel #(.GEI_CNT(GEI_CNT), .SEL_W(SEL_W)) u_ext (
    .pend(gext_pend), .en(gext_en_q), .gsel(gsel_q),
    .picked(picked), .any_enabled(any_en)
  );

  vsirq_timer_cmp #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .delta(tdelta_q), .cmp(tcmp_q), .due_q(due_q)
  );

  assign vseip = sw_vseip | plat_vseip | picked;
  assign vstip = sw_vstip | due_q;
  assign sgeip = any_en;
endmodule

// File: rtl/vsirq_chk.sv
module vsirq_chk #(
  parameter int GEI_CNT = 5,
  parameter int SEL_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_vseip,
  input logic             sw_vstip,
  input logic             plat_vseip,
  input logic [GEI_CNT:0] gext_pend,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic [5:0]       sel_field,
  input logic             vseip,
  input logic             vstip,
  input logic             sgeip,
  input logic [GEI_CNT:0] gext_en_q,
  input logic [SEL_W-1:0] gsel_q
);
  // R1: sources force the external pending bit
  a_r1_sources_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_vseip || plat_vseip) |-> vseip);
  // R1: selector 0 contributes nothing
  a_r1_sel_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (gsel_q == '0 && !sw_vseip && !plat_vseip) |-> !vseip);
  // R2: software timer bit forces the timer pending bit
  a_r2_sw_timer: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vstip |-> vstip);
  // R3: no enabled line, no supervisor guest-external pending
  a_r3_no_enabled_line: assert property (@(posedge clk) disable iff (!rst_n)
    ((gext_pend[GEI_CNT:1] & gext_en_q[GEI_CNT:1]) == '0) |-> !sgeip);
  // R4: enable bit 0 is never set
  a_r4_en_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    !gext_en_q[0]);
  // R6: stored selector stays in range
  a_r6_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    gsel_q <= SEL_W'(GEI_CNT));
  // R6: illegal selector write keeps the old value
  a_r6_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3 && sel_field > 6'(GEI_CNT)) |=> $stable(gsel_q));
endmodule

bind vs_irq_pending_gen vsirq_chk #(.GEI_CNT(GEI_CNT), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_vseip(sw_vseip), .sw_vstip(sw_vstip),
  .plat_vseip(plat_vseip), .gext_pend(gext_pend), .cfg_we(cfg_we),
  .cfg_sel(cfg_sel), .sel_field(cfg_wdata[5:0]), .vseip(vseip),
  .vstip(vstip), .sgeip(sgeip), .gext_en_q(gext_en_q), .gsel_q(gsel_q)
);

// File: tb/sim_vs_irq_pending_gen.sv
module sim_vs_irq_pending_gen;
  localparam int GEI = 5;
  localparam int SW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_vseip = 0, sw_vstip = 0, plat_vseip = 0;
  logic [GEI:0] gext_pend = '0;
  logic [63:0] time_now = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic vseip, vstip, sgeip;
  logic [GEI:0] gext_en_q;
  logic [63:0] tdelta_q, tcmp_q;
  logic [SW-1:0] gsel_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  vs_irq_pending_gen #(.GEI_CNT(GEI)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_vseip(sw_vseip), .sw_vstip(sw_vstip),
    .plat_vseip(plat_vseip), .gext_pend(gext_pend), .time_now(time_now),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .vseip(vseip), .vstip(vstip), .sgeip(sgeip), .gext_en_q(gext_en_q),
    .tdelta_q(tdelta_q), .tcmp_q(tcmp_q), .gsel_q(gsel_q)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [63:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [SW-1:0] exp_sel;
    @(negedge clk); tick(); tick();
    rst_n = 1; #1;
    // R8 reset state
    check("R8 sel", 64'(gsel_q), 0);
    check("R8 en", 64'(gext_en_q), 0);
    check("R8 delta", tdelta_q, 0);
    check("R8 cmp", tcmp_q, '1);
    check("R8 vstip", 64'(vstip), 0);
    check("R8 vseip", 64'(vseip), 0);
    @(negedge clk);

    // R3/R4/R5: every enable write vs every pending pattern
    for (int e = 0; e < 64; e++) begin
      wr(2'd0, 64'(e));
      check("R4 en readback", 64'(gext_en_q), 64'(e & 62));
      for (int p = 0; p < 64; p++) begin
        gext_pend = 6'(p); #1;
        check("R3 sgeip", 64'(sgeip), 64'(((p & e & 62) != 0) ? 1 : 0));
        @(negedge clk);
      end
    end
    wr(2'd0, 64'd0);

    // R6: every selector field value
    exp_sel = '0;
    for (int v = 63; v >= 0; v--) begin
      wr(2'd3, 64'hFFFF_0000_0000_0000 | 64'(v));
      if (v <= GEI) exp_sel = SW'(v);
      check("R6 selector", 64'(gsel_q), 64'(exp_sel));
    end

    // R1: selector x pending x sideband sources
    for (int s = 0; s <= GEI; s++) begin
      wr(2'd3, 64'(s));
      for (int p = 0; p < 64; p++) begin
        for (int b = 0; b < 4; b++) begin
          gext_pend = 6'(p); sw_vseip = b[0]; plat_vseip = b[1]; #1;
          check("R1 vseip", 64'(vseip),
                64'((b != 0 || (s != 0 && ((p >> s) & 1) != 0)) ? 1 : 0));
          @(negedge clk);
        end
      end
    end
    sw_vseip = 0; plat_vseip = 0; gext_pend = '0;

    // R5: offset / compare readback
    wr(2'd1, 64'h0123_4567_89AB_CDEF);
    check("R5 delta", tdelta_q, 64'h0123_4567_89AB_CDEF);
    wr(2'd2, 64'hFEDC_BA98_7654_3210);
    check("R5 cmp", tcmp_q, 64'hFEDC_BA98_7654_3210);

    // R2: timer compare incl. wrap
    begin
      logic [63:0] tv [7];
      logic [63:0] dv [7];
      logic [63:0] cv [7];
      tv = '{64'd100, 64'd99, 64'd101, '1, '1, 64'd5, 64'd5};
      dv = '{64'd0, 64'd0, 64'd0, 64'd1, 64'd1, '1, '1};
      cv = '{64'd100, 64'd100, 64'd100, 64'd0, 64'd1, 64'd4, 64'd5};
      for (int k = 0; k < 7; k++) begin
        wr(2'd1, dv[k]);
        wr(2'd2, cv[k]);
        time_now = tv[k];
        tick();
        check("R2 vstip", 64'(vstip), 64'(((tv[k] + dv[k]) >= cv[k]) ? 1 : 0));
      end
    end

    // R7: latency of one edge
    wr(2'd1, 64'd0); wr(2'd2, 64'd100);
    time_now = 64'd99; tick();
    check("R7 before", 64'(vstip), 0);
    time_now = 64'd100; #1;
    check("R7 not yet", 64'(vstip), 0);
    tick();
    check("R7 after", 64'(vstip), 1);
    time_now = 64'd10; tick();
    sw_vstip = 1; #1;
    check("R2 sw timer", 64'(vstip), 1);
    sw_vstip = 0; #1;
    check("R2 sw timer off", 64'(vstip), 0);

    done = 1;
    finish_run();
  end
endmodule